// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block takes eight interrupt request lines and decides which one, if any, should be presented to the processor. Each line is captured into a request register. A per-line trigger-mode input selects whether the request bit follows the line's level or latches on a rising edge. The captured requests are filtered by a mask input. The highest-priority survivor is then compared against the highest-priority bit of an in-service register. Priority is circular: a base input names the line that holds the top priority, and the others follow in ascending line order with wrap-around.

The winner's line number and a valid flag are produced combinationally from the registered state. A registered interrupt line follows the valid flag one clock later. An acknowledge input marks the current winner as in service, and it drops a latched edge request. An end-of-interrupt input with a line index clears one in-service bit. When the block acts as master with special fully nested mode enabled, the in-service bit of the cascade line (line 2) is left out of the comparison. A second request on that line can therefore still get through.

Top module: `pic_rot_resolver`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) has its request bit equal, one clock later, to the line's value at the previous rising clock edge. Acknowledge never clears it.
- R2: A line whose trigger-mode bit is 0 (edge) sets its request bit only when the line was low at one clock edge and high at the next. A line held high does not set it again until it has been low for at least one edge. Acknowledging that line clears the bit.
- R3: A line whose mask bit is 1 never wins. With every mask bit set, valid_o is 0.
- R4: Priority position p (0 highest) belongs to line (p + base_i) mod 8. Among unmasked requests the lowest position wins, and idx_o reports the winner's line number.
- R5: A request is granted only if its position is strictly smaller than the smallest position among the in-service bits. A request at an equal or larger position gives valid_o = 0.
- R6: When sfnm_i = 1 and master_i = 1, in-service bit 2 is ignored in the comparison. In every other combination it counts.
- R7: ack_i with valid_o = 1 sets the in-service bit of idx_o. ack_i with valid_o = 0 changes no in-service bit.
- R8: eoi_i clears in-service bit eoi_idx_i at the next clock edge.
- R9: irq_o equals valid_o as it stood just before the most recent clock edge. It is 0 after a cycle with no eligible request.
- R10: A synchronous reset (rst = 1 at a clock edge) clears the request, previous-level and in-service registers and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Interrupt request lines |
| trig_lvl_i | input | 8 | Per-line trigger mode: 1 level, 0 edge |
| mask_i | input | 8 | Per-line mask: 1 blocks the line |
| base_i | input | 3 | Line holding top priority |
| sfnm_i | input | 1 | Special fully nested mode enable |
| master_i | input | 1 | 1 when the block is the master controller |
| ack_i | input | 1 | Acknowledge the current winner |
| eoi_i | input | 1 | End of interrupt for line eoi_idx_i |
| eoi_idx_i | input | 3 | Line whose in-service bit is cleared |
| valid_o | output | 1 | A request is eligible |
| idx_o | output | 3 | Line number of the winner |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach from the ports is a request blocked or admitted purely by in-service state. This includes a level request at the same position as an in-service bit, a lower request under a rotated base, and the cascade line re-requesting while itself in service. The stimulus builds that state by acknowledging a winner while its level line stays high. It then rotates the base, changes the mask or the nested-mode inputs, and issues end-of-interrupt commands to show the blocked request reappearing. Edge behaviour is exercised by holding a line high across an acknowledge and then re-arming it with a low cycle.

// File: rtl/pic_rot_pkg.sv
package pic_rot_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    localparam int POS_W = IDX_W + 1;

    typedef logic [LINES-1:0] vec_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic valid;
        idx_t idx;
    } grant_t;

    // Reorder a line vector so that bit p holds line (p + base) mod LINES.
    function automatic vec_t rotate_down(vec_t v, idx_t base);
        vec_t r;
        for (int p = 0; p < LINES; p++) begin
            r[p] = v[idx_t'(idx_t'(p) + base)];
        end
        return r;
    endfunction

    // Lowest set position; LINES when empty.
    function automatic pos_t first_pos(vec_t v);
        pos_t f;
        f = pos_t'(LINES);
        for (int p = LINES - 1; p >= 0; p--) begin
            if (v[p]) f = pos_t'(p);
        end
        return f;
    endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
    import pic_rot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t req_i,
    input  vec_t trig_lvl_i,
    input  vec_t ack_clr_i,
    output vec_t irr_o
);
    vec_t irr_q;
    vec_t prev_q;
    vec_t irr_d;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            if (trig_lvl_i[i]) irr_d[i] = req_i[i];
            else               irr_d[i] = (irr_q[i] & ~ack_clr_i[i]) | (req_i[i] & ~prev_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            prev_q <= '0;
        end else begin
            irr_q  <= irr_d;
            prev_q <= req_i;
        end
    end

    assign irr_o = irr_q;

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_chk
            // R1
            level_follow_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(trig_lvl_i[g])) |-> (irr_q[g] == $past(req_i[g])));
            // R2
            edge_rise_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(trig_lvl_i[g]) && !$past(irr_q[g]) && irr_q[g])
                |-> ($past(req_i[g]) && !$past(prev_q[g])));
        end
    endgenerate
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
    import pic_rot_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input  vec_t   irr_i,
    input  vec_t   isr_i,
    input  vec_t   mask_i,
    input  idx_t   base_i,
    input  logic   sfnm_i,
    input  logic   master_i,
    output grant_t grant_o
);
    vec_t pend;
    vec_t busy;
    pos_t win_pos;
    pos_t cur_pos;

    always_comb begin
        pend = irr_i & ~mask_i;
        busy = isr_i;
        if (sfnm_i && master_i) busy[CASCADE_LINE] = 1'b0;
        win_pos = first_pos(rotate_down(pend, base_i));
        cur_pos = first_pos(rotate_down(busy, base_i));
        grant_o.valid = (win_pos != pos_t'(LINES)) && (win_pos < cur_pos);
        grant_o.idx   = idx_t'(win_pos[IDX_W-1:0] + base_i);
    end

    // R3
    masked_win_chk: assert final (!grant_o.valid || !mask_i[grant_o.idx]);
    // R4
    win_pending_chk: assert final (!grant_o.valid || irr_i[grant_o.idx]);
endmodule

// File: rtl/pic_rot_resolver.sv
module pic_rot_resolver
    import pic_rot_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       req_i,
    input  logic [7:0]       trig_lvl_i,
    input  logic [7:0]       mask_i,
    input  logic [2:0]       base_i,
    input  logic             sfnm_i,
    input  logic             master_i,
    input  logic             ack_i,
    input  logic             eoi_i,
    input  logic [2:0]       eoi_idx_i,
    output logic             valid_o,
    output logic [2:0]       idx_o,
    output logic             irq_o
);
    vec_t   irr;
    vec_t   isr_q;
    vec_t   ack_set;
    vec_t   eoi_clr;
    grant_t grant;
    logic   irq_q;

    always_comb begin
        ack_set = '0;
        eoi_clr = '0;
        if (ack_i && grant.valid) ack_set[grant.idx] = 1'b1;
        if (eoi_i) eoi_clr[eoi_idx_i] = 1'b1;
    end

    pic_req_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .trig_lvl_i (trig_lvl_i),
        .ack_clr_i  (ack_set),
        .irr_o      (irr)
    );

    pic_prio_resolve #(.CASCADE_LINE(CASCADE_LINE)) u_resolve (
        .irr_i    (irr),
        .isr_i    (isr_q),
        .mask_i   (mask_i),
        .base_i   (base_i),
        .sfnm_i   (sfnm_i),
        .master_i (master_i),
        .grant_o  (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            irq_q <= 1'b0;
        end else begin
            isr_q <= (isr_q & ~eoi_clr) | ack_set;
            irq_q <= grant.valid;
        end
    end

    assign valid_o = grant.valid;
    assign idx_o   = grant.idx;
    assign irq_o   = irq_q;

    // R7
    ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && valid_o) |=> isr_q[$past(idx_o)]);
    // R8
    eoi_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !(ack_i && valid_o && idx_o == eoi_idx_i)) |=> !isr_q[$past(eoi_idx_i)]);
    // R3
    all_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (&mask_i) |=> !irq_o);
    // R7
    no_ack_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_i && !eoi_i) |=> $stable(isr_q));
endmodule

// File: tb/pic_rot_resolver_bench.sv
module pic_rot_resolver_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] req = 0, trig = 0, mask = 0;
    logic [2:0] base = 0, eoi_idx = 0;
    logic       sfnm = 0, master = 0, ack = 0, eoi = 0;
    logic       valid, irq;
    logic [2:0] idx;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_rot_resolver u_pic_rot_resolver (
        .clk(clk), .rst(rst), .req_i(req), .trig_lvl_i(trig), .mask_i(mask),
        .base_i(base), .sfnm_i(sfnm), .master_i(master), .ack_i(ack),
        .eoi_i(eoi), .eoi_idx_i(eoi_idx), .valid_o(valid), .idx_o(idx), .irq_o(irq)
    );

    // {req, mask, base, exp_valid, exp_idx}, all lines level-triggered, nothing in service
    localparam logic [22:0] VEC [10] = '{
        {8'h00, 8'h00, 3'd0, 1'b0, 3'd0},
        {8'h81, 8'h00, 3'd0, 1'b1, 3'd0},
        {8'h81, 8'h00, 3'd1, 1'b1, 3'd7},
        {8'h24, 8'h00, 3'd3, 1'b1, 3'd5},
        {8'h24, 8'h20, 3'd3, 1'b1, 3'd2},
        {8'hFF, 8'hFF, 3'd0, 1'b0, 3'd0},
        {8'hFF, 8'h7F, 3'd0, 1'b1, 3'd7},
        {8'h10, 8'h00, 3'd4, 1'b1, 3'd4},
        {8'h0C, 8'h00, 3'd7, 1'b1, 3'd2},
        {8'h41, 8'h00, 3'd6, 1'b1, 3'd6}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic exp_v, logic [2:0] exp_i);
        n_chk++;
        if (valid !== exp_v || (exp_v && idx !== exp_i)) begin
            n_bad++;
            $display("FAIL %s: valid=%0b idx=%0d expected valid=%0b idx=%0d",
                     tag, valid, idx, exp_v, exp_i);
        end
    endtask

    task automatic chk_irq(string tag, logic exp);
        n_chk++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s: irq=%0b expected %0b", tag, irq, exp);
        end
    endtask

    task automatic pulse_ack();
        ack = 1; step(); ack = 0;
    endtask

    task automatic pulse_eoi(logic [2:0] i);
        eoi = 1; eoi_idx = i; step(); eoi = 0;
    endtask

    task automatic do_reset();
        rst = 1; step(); rst = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        chk("R10 reset outputs", 1'b0, 3'd0);
        chk_irq("R10 reset irq", 1'b0);
        rst = 0;

        // table: level lines, mask and rotation
        trig = 8'hFF;
        for (int k = 0; k < 10; k++) begin
            {req, mask, base} = VEC[k][22:4];
            step(); step();
            chk($sformatf("R4/R3 vector %0d", k), VEC[k][3], VEC[k][2:0]);
            chk_irq($sformatf("R9 vector %0d irq", k), VEC[k][3]);
        end

        // R9: irq lags valid by one edge
        req = 0; mask = 0; base = 0; step(); step();
        req = 8'h01; step();
        chk("R1 level latched", 1'b1, 3'd0);
        chk_irq("R9 irq still low", 1'b0);
        step();
        chk_irq("R9 irq follows", 1'b1);
        req = 0; step();
        chk("R1 level drops", 1'b0, 3'd0);
        step();
        chk_irq("R9 irq drops", 1'b0);

        // R2: edge lines
        do_reset();
        trig = 8'h00; req = 0; step();
        req = 8'h08; step();
        chk("R2 rising edge latched", 1'b1, 3'd3);
        pulse_ack();
        chk("R2 ack clears edge request", 1'b0, 3'd0);
        step(); step(); step();
        chk("R2 held high no re-set", 1'b0, 3'd0);
        pulse_eoi(3'd3);
        req = 0; step();
        req = 8'h08; step();
        chk("R2 re-armed edge", 1'b1, 3'd3);

        // R5 / R7 / R8 with in-service state
        pulse_ack();
        trig = 8'h02; req = 8'h0A; step();
        chk("R5 higher preempts in-service", 1'b1, 3'd1);
        pulse_ack();
        chk("R5 equal position blocked", 1'b0, 3'd0);
        pulse_eoi(3'd1);
        chk("R8 eoi reopens level request R1", 1'b1, 3'd1);
        trig = 8'h22; req = 8'h2A; step();
        mask = 8'h02; step();
        chk("R5 lower position blocked", 1'b0, 3'd0);
        base = 3'd4; step();
        chk("R4 rotation moves in-service rank", 1'b1, 3'd5);

        // R10 mid-run reset
        rst = 1; step();
        chk("R10 reset mid-run", 1'b0, 3'd0);
        chk_irq("R10 reset irq mid-run", 1'b0);
        rst = 0; req = 0; trig = 0; mask = 0; base = 0; step();

        // R7: ack without winner is ignored
        trig = 8'hFF; req = 8'h01; mask = 8'h01; step();
        chk("R3 masked line", 1'b0, 3'd0);
        pulse_ack();
        mask = 8'h00; step();
        chk("R7 ack with no winner ignored", 1'b1, 3'd0);

        // R6: special fully nested mode
        do_reset();
        trig = 8'hFF; req = 8'h04; step();
        chk("R6 cascade line wins", 1'b1, 3'd2);
        pulse_ack();
        chk("R6 in-service counts when off", 1'b0, 3'd0);
        sfnm = 1; master = 1; step();
        chk("R6 master sfnm ignores bit 2", 1'b1, 3'd2);
        master = 0; step();
        chk("R6 slave keeps bit 2", 1'b0, 3'd0);
        sfnm = 0; master = 1; step();
        chk("R6 master without sfnm keeps bit 2", 1'b0, 3'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule